// File: doc/BRIEF.md
# Mode Register Loader with Read Latency Scheduler

This block sits in a memory controller beside the command path. It accepts mode-load commands that carry a 14-bit address field. It sorts each command into one of three kinds, using the seven upper address bits: a plain operating-mode load, a load that also starts a DLL reset, or a reserved combination. From the seven low bits it keeps three settings: burst length, burst type and read latency. Reserved combinations, and low-field codes that have no meaning, are reported and change nothing.

The block also times read data. Each accepted read enters a short delay line, and a data-valid marker comes out after the programmed latency of 2 or 2.5 command clocks. The block runs on a clock at twice the command rate, so a latency of 2.5 clocks lands on the half-cycle point. The marker then stays high for as long as the burst occupies the data bus. A frequency input is compared with the limits that apply to the stored latency, and a warning output is raised when the setting does not suit that frequency.

Top module: `mode_latency_ctl`

## Requirements
- R1: After reset the stored latency is 2.5 clocks (`lat_half` = 5), the burst length is 2 and the burst type is sequential (`burst_ilv` = 0). All flags are low, and `rise_slot` is high in the first cycle after reset is released.
- R2: `rise_slot` alternates every fast-clock cycle. Commands are taken only at a rising edge of the fast clock that ends a cycle in which `rise_slot` is high. A command presented in any other cycle has no effect on any output.
- R3: A mode load whose bits 13..7 are all zero stores the following fields. Bits 2..0 give the burst length: 001 = 2, 010 = 4, 011 = 8. Bit 3 gives the burst type: 0 = sequential, 1 = interleaved. Bits 6..4 give the latency: 010 = 2 clocks, which reads as `lat_half` = 4, and 110 = 2.5 clocks, which reads as `lat_half` = 5.
- R4: A mode load with bit 8 at one and bits 13..9 and 7 at zero stores the fields in the same way and sets `dll_pend`. `dll_pend` stays set until a later accepted load of the R3 kind clears it.
- R5: A mode load with any other value in bits 13..7 stores nothing and leaves `dll_pend` as it was. It raises `rsvd_hit` for exactly one cycle, the cycle after the accepting edge.
- R6: A mode load of the R3 or R4 kind whose burst code or latency code is not listed in R3 stores nothing and leaves `dll_pend` as it was. It raises `field_bad` for one cycle, the cycle after the accepting edge.
- R7: For a read accepted at fast edge E, `rd_dv` first goes high after fast edge E+4 when the latency is 2 clocks, and after fast edge E+5 when it is 2.5 clocks.
- R8: `rd_dv` stays high for a number of fast cycles equal to the burst length, which is burst length / 2 command clocks. The burst length used is the one in force when the marker starts. If a new marker starts while one is running, the count restarts from the full burst length.
- R9: The latency for a read is fixed when the read is accepted. A mode load taken at the same edge as the read, or later, affects only reads accepted afterwards.
- R10: `cfg_warn` is high when `freq_mhz` is below 75, or above the limit for the stored latency. The limit is 100 for 2 clocks and 133 for 2.5 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock at twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_cmd | input | 1 | Mode-load command strobe |
| rd_cmd | input | 1 | Read command strobe |
| cmd_addr | input | 14 | Address field carried with a mode load |
| freq_mhz | input | 8 | Command clock frequency in MHz |
| rise_slot | output | 1 | High in the fast cycle whose ending edge is a command edge |
| burst_len | output | 4 | Stored burst length (2, 4 or 8) |
| burst_ilv | output | 1 | Stored burst type, 1 = interleaved |
| lat_half | output | 3 | Stored read latency in half clocks (4 or 5) |
| dll_pend | output | 1 | A DLL-reset load still awaits a normal load |
| rsvd_hit | output | 1 | One-cycle pulse: reserved upper bits were seen |
| field_bad | output | 1 | One-cycle pulse: reserved burst or latency code was seen |
| cfg_warn | output | 1 | Latency setting does not suit `freq_mhz` |
| rd_dv | output | 1 | Read data-valid marker |

## Verification
A mode load and a read can both be taken at the same command edge. In that case the read must keep the latency that was in force before the edge, while the burst length it uses is the one in force when its marker starts. The bench provokes this with a directed case in which the new load shortens the latency at the edge that accepts a read. It also provokes it with random traffic in which loads and reads collide freely while earlier reads are still in flight. A bench model keeps the latency with each accepted read and takes the burst length at each marker start. Every cycle, `rd_dv` and the stored settings are compared with that model.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int CMD_ADDR_W = 14;
  localparam int OP_W       = 7;
  localparam int HI_W       = CMD_ADDR_W - OP_W;
  localparam int BLV_W      = 4;
  localparam int HALF_W     = 3;
  localparam logic [HALF_W-1:0] LAT2_HALF  = 3'd4;
  localparam logic [HALF_W-1:0] LAT25_HALF = 3'd5;

  typedef enum logic [1:0] {
    LD_NORMAL = 2'd0,
    LD_DLL    = 2'd1,
    LD_RSVD   = 2'd2
  } ld_kind_e;

  typedef struct packed {
    logic [BLV_W-1:0]  blen;
    logic              ilv;
    logic [HALF_W-1:0] lat_half;
  } mode_t;

  // Upper-field class: all zero, only the DLL bit set, or anything else.
  function automatic ld_kind_e classify_hi(input logic [HI_W-1:0] hi);
    if (hi == '0) return LD_NORMAL;
    if (hi == HI_W'(2)) return LD_DLL;
    return LD_RSVD;
  endfunction

  // Burst code to beat count; 0 means the code is reserved.
  function automatic logic [BLV_W-1:0] blen_of(input logic [2:0] code);
    case (code)
      3'd1:    return BLV_W'(2);
      3'd2:    return BLV_W'(4);
      3'd3:    return BLV_W'(8);
      default: return '0;
    endcase
  endfunction

  // Latency code to half-clock count; 0 means the code is reserved.
  function automatic logic [HALF_W-1:0] lat_of(input logic [2:0] code);
    case (code)
      3'b010:  return LAT2_HALF;
      3'b110:  return LAT25_HALF;
      default: return '0;
    endcase
  endfunction

  // True when the frequency lies outside the window of the stored latency.
  function automatic logic freq_bad(input int f, input logic [HALF_W-1:0] lat,
                                    input int fmin, input int f2, input int f25);
    return (f < fmin) || (f > ((lat == LAT2_HALF) ? f2 : f25));
  endfunction
endpackage

// File: rtl/mlc_decode.sv
module mlc_decode
  import mlc_pkg::*;
(
  input  logic [CMD_ADDR_W-1:0] addr,
  output ld_kind_e              kind,
  output mode_t                 cand,
  output logic                  fields_ok
);
  assign kind          = classify_hi(addr[CMD_ADDR_W-1:OP_W]);
  assign cand.blen     = blen_of(addr[2:0]);
  assign cand.ilv      = addr[3];
  assign cand.lat_half = lat_of(addr[6:4]);
  assign fields_ok     = (cand.blen != '0) && (cand.lat_half != '0);
endmodule

// File: rtl/mlc_mode_reg.sv
module mlc_mode_reg
  import mlc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld_go,
  input  ld_kind_e kind,
  input  mode_t    cand,
  input  logic     fields_ok,
  output mode_t    mode,
  output logic     load_ok,
  output logic     dll_pend,
  output logic     rsvd_hit,
  output logic     field_bad
);
  localparam mode_t RESET_MODE = '{blen: BLV_W'(2), ilv: 1'b0, lat_half: LAT25_HALF};

  logic is_rsvd;
  assign is_rsvd = (kind == LD_RSVD);
  assign load_ok = ld_go && !is_rsvd && fields_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= RESET_MODE;
      dll_pend  <= 1'b0;
      rsvd_hit  <= 1'b0;
      field_bad <= 1'b0;
    end else begin
      rsvd_hit  <= ld_go && is_rsvd;
      field_bad <= ld_go && !is_rsvd && !fields_ok;
      if (load_ok) begin
        mode     <= cand;
        dll_pend <= (kind == LD_DLL);
      end
    end
  end
endmodule

// File: rtl/mlc_rd_line.sv
module mlc_rd_line
  import mlc_pkg::*;
#(
  parameter int MAX_HALF = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [HALF_W-1:0] lat_half,
  input  logic [BLV_W-1:0]  blen,
  output logic              tap_fire,
  output logic              rd_dv
);
  // A read enters closer to the output when its latency is shorter, so the
  // latency is frozen inside the line at acceptance.
  logic [MAX_HALF-1:0] sr, sr_nxt;
  logic [HALF_W-1:0]   entry;
  logic [BLV_W-1:0]    left;

  assign entry = HALF_W'(MAX_HALF) - lat_half;

  for (genvar i = 0; i < MAX_HALF; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign sr_nxt[i] = rd_go && (entry == HALF_W'(i));
    end else begin : g_body
      assign sr_nxt[i] = sr[i-1] | (rd_go && (entry == HALF_W'(i)));
    end
  end

  assign tap_fire = sr[MAX_HALF-1];
  assign rd_dv    = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else begin
      sr <= sr_nxt;
      if (tap_fire)          left <= blen;
      else if (left != '0)   left <= left - BLV_W'(1);
    end
  end
endmodule

// File: rtl/mode_latency_ctl.sv
module mode_latency_ctl
  import mlc_pkg::*;
#(
  parameter int FREQ_W    = 8,
  parameter int FMIN      = 75,
  parameter int FMAX_CL2  = 100,
  parameter int FMAX_CL25 = 133,
  parameter int MAX_HALF  = 5
) (
  input  logic                  clk2x,
  input  logic                  rst_n,
  input  logic                  mrs_cmd,
  input  logic                  rd_cmd,
  input  logic [CMD_ADDR_W-1:0] cmd_addr,
  input  logic [FREQ_W-1:0]     freq_mhz,
  output logic                  rise_slot,
  output logic [BLV_W-1:0]      burst_len,
  output logic                  burst_ilv,
  output logic [HALF_W-1:0]     lat_half,
  output logic                  dll_pend,
  output logic                  rsvd_hit,
  output logic                  field_bad,
  output logic                  cfg_warn,
  output logic                  rd_dv
);
  logic     ph;
  logic     mrs_go, rd_go;
  ld_kind_e kind;
  mode_t    cand, mode;
  logic     fields_ok, load_ok, tap_fire;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  assign rise_slot = ~ph;
  assign mrs_go    = mrs_cmd & rise_slot;
  assign rd_go     = rd_cmd & rise_slot;

  mlc_decode u_dec (
    .addr      (cmd_addr),
    .kind      (kind),
    .cand      (cand),
    .fields_ok (fields_ok)
  );

  mlc_mode_reg u_mr (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .ld_go     (mrs_go),
    .kind      (kind),
    .cand      (cand),
    .fields_ok (fields_ok),
    .mode      (mode),
    .load_ok   (load_ok),
    .dll_pend  (dll_pend),
    .rsvd_hit  (rsvd_hit),
    .field_bad (field_bad)
  );

  mlc_rd_line #(.MAX_HALF(MAX_HALF)) u_rl (
    .clk      (clk2x),
    .rst_n    (rst_n),
    .rd_go    (rd_go),
    .lat_half (mode.lat_half),
    .blen     (mode.blen),
    .tap_fire (tap_fire),
    .rd_dv    (rd_dv)
  );

  assign burst_len = mode.blen;
  assign burst_ilv = mode.ilv;
  assign lat_half  = mode.lat_half;
  assign cfg_warn  = freq_bad(int'(freq_mhz), mode.lat_half, FMIN, FMAX_CL2, FMAX_CL25);
endmodule

// File: rtl/mlc_checker.sv
module mlc_checker
  import mlc_pkg::*;
(
  input logic                  clk2x,
  input logic                  rst_n,
  input logic                  mrs_cmd,
  input logic [CMD_ADDR_W-1:0] cmd_addr,
  input logic                  rise_slot,
  input logic [BLV_W-1:0]      burst_len,
  input logic                  burst_ilv,
  input logic [HALF_W-1:0]     lat_half,
  input logic                  dll_pend,
  input logic                  rsvd_hit,
  input logic                  field_bad,
  input logic                  tap_fire,
  input logic                  load_ok,
  input logic                  rd_dv
);
  a_r2_slot_fall: assert property (@(posedge clk2x) disable iff (!rst_n)
    rise_slot |=> !rise_slot);
  a_r2_slot_rise: assert property (@(posedge clk2x) disable iff (!rst_n)
    !rise_slot |=> rise_slot);
  a_r3_legal_settings: assert property (@(posedge clk2x) disable iff (!rst_n)
    (lat_half == 3'd4 || lat_half == 3'd5) && $countones(burst_len) == 1 && !burst_len[0]);
  a_r4_dll_source: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(dll_pend) |-> $past(mrs_cmd && rise_slot && cmd_addr[13:7] == 7'd2));
  a_r5_rsvd_keeps: assert property (@(posedge clk2x) disable iff (!rst_n)
    rsvd_hit |-> $stable(lat_half) && $stable(burst_len) && $stable(burst_ilv) && $stable(dll_pend));
  a_r6_bad_keeps: assert property (@(posedge clk2x) disable iff (!rst_n)
    field_bad |-> $stable(lat_half) && $stable(burst_len) && $stable(burst_ilv) && $stable(dll_pend));
  a_r6_flags_apart: assert property (@(posedge clk2x) disable iff (!rst_n)
    !(rsvd_hit && field_bad) && !(load_ok && !rise_slot));
  a_r8_dv_follows_tap: assert property (@(posedge clk2x) disable iff (!rst_n)
    tap_fire |=> rd_dv);
  a_r7_dv_needs_tap: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(rd_dv) |-> $past(tap_fire));
endmodule

bind mode_latency_ctl mlc_checker u_chk (
  .clk2x     (clk2x),
  .rst_n     (rst_n),
  .mrs_cmd   (mrs_cmd),
  .cmd_addr  (cmd_addr),
  .rise_slot (rise_slot),
  .burst_len (burst_len),
  .burst_ilv (burst_ilv),
  .lat_half  (lat_half),
  .dll_pend  (dll_pend),
  .rsvd_hit  (rsvd_hit),
  .field_bad (field_bad),
  .tap_fire  (tap_fire),
  .load_ok   (load_ok),
  .rd_dv     (rd_dv)
);

// File: tb/sim_mode_latency_ctl.sv
module sim_mode_latency_ctl;
  localparam int CLK_PER = 10;

  logic        clk2x = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrs_cmd = 1'b0, rd_cmd = 1'b0;
  logic [13:0] cmd_addr = '0;
  logic [7:0]  freq_mhz = 8'd90;
  logic        rise_slot, burst_ilv, dll_pend, rsvd_hit, field_bad, cfg_warn, rd_dv;
  logic [3:0]  burst_len;
  logic [2:0]  lat_half;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PER/2) clk2x = ~clk2x;

  mode_latency_ctl u0 (
    .clk2x(clk2x), .rst_n(rst_n), .mrs_cmd(mrs_cmd), .rd_cmd(rd_cmd),
    .cmd_addr(cmd_addr), .freq_mhz(freq_mhz), .rise_slot(rise_slot),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .lat_half(lat_half),
    .dll_pend(dll_pend), .rsvd_hit(rsvd_hit), .field_bad(field_bad),
    .cfg_warn(cfg_warn), .rd_dv(rd_dv)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- bench model, built from the requirements ----------------
  int m_bl, m_lat, m_ilv, m_dll, m_rsvd, m_bad, m_ph, m_dv, edge_n, m_end;
  bit pend [int];

  function automatic int bl_code(input int c);
    return (c >= 1 && c <= 3) ? (1 << c) : 0;
  endfunction
  function automatic int lat_code(input int c);
    if (c == 2) return 4;
    if (c == 6) return 5;
    return 0;
  endfunction
  function automatic bit warn_exp(input int f, input int lat);
    int top;
    top = (lat == 4) ? 100 : 133;
    return (f < 75) || (f > top);
  endfunction
  function automatic logic [13:0] mk(input int hi, input int cl, input int t, input int bl);
    return {7'(hi), 3'(cl), 1'(t), 3'(bl)};
  endfunction

  always @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      m_bl = 2; m_lat = 5; m_ilv = 0; m_dll = 0; m_rsvd = 0; m_bad = 0;
      m_ph = 0; m_dv = 0; edge_n = 0; m_end = 0; pend.delete();
    end else begin
      int hi, nb, nl;
      edge_n++;
      if (pend.exists(edge_n)) begin          // R8: burst length at start
        m_end = edge_n + m_bl;
        pend.delete(edge_n);
      end
      if (m_ph == 0 && rd_cmd) pend[edge_n + m_lat] = 1'b1;   // R7, R9
      m_rsvd = 0; m_bad = 0;
      if (m_ph == 0 && mrs_cmd) begin
        hi = int'(cmd_addr[13:7]);
        nb = bl_code(int'(cmd_addr[2:0]));
        nl = lat_code(int'(cmd_addr[6:4]));
        if (hi != 0 && hi != 2) m_rsvd = 1;
        else if (nb == 0 || nl == 0) m_bad = 1;
        else begin
          m_bl = nb; m_lat = nl; m_ilv = int'(cmd_addr[3]); m_dll = (hi == 2);
        end
      end
      m_ph ^= 1;
      m_dv = (edge_n < m_end) ? 1 : 0;
    end
  end

  // Per-cycle comparison, away from the clock edge
  always @(negedge clk2x) begin
    #1;
    if (rst_n && !done) begin
      chk("R2 rise_slot", int'(rise_slot), (m_ph == 0) ? 1 : 0);
      chk("R3 burst_len", int'(burst_len), m_bl);
      chk("R3 burst_ilv", int'(burst_ilv), m_ilv);
      chk("R3 lat_half", int'(lat_half), m_lat);
      chk("R4 dll_pend", int'(dll_pend), m_dll);
      chk("R5 rsvd_hit", int'(rsvd_hit), m_rsvd);
      chk("R6 field_bad", int'(field_bad), m_bad);
      chk("R7 R8 rd_dv", int'(rd_dv), m_dv);
      chk("R10 cfg_warn", int'(cfg_warn), int'(warn_exp(int'(freq_mhz), m_lat)));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit m, input bit r, input logic [13:0] a);
    mrs_cmd = m; rd_cmd = r; cmd_addr = a;
    @(negedge clk2x);
    mrs_cmd = 0; rd_cmd = 0;
  endtask
  task automatic issue(input bit m, input bit r, input logic [13:0] a);
    while (m_ph != 0) @(negedge clk2x);
    cyc(m, r, a);
  endtask
  task automatic dv_window(input string tag, input int lat, input int bl);
    // called at the negedge right after the accepting edge E
    for (int k = 1; k < lat; k++) begin
      @(negedge clk2x); chk({tag, " before start"}, int'(rd_dv), 0);
    end
    for (int k = 0; k < bl; k++) begin
      @(negedge clk2x); chk({tag, " active"}, int'(rd_dv), 1);
    end
    @(negedge clk2x); chk({tag, " after end"}, int'(rd_dv), 0);
  endtask

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk2x);
    rst_n = 1'b1;
    #1;
    // R1 reset defaults
    chk("R1 lat_half", int'(lat_half), 5);
    chk("R1 burst_len", int'(burst_len), 2);
    chk("R1 burst_ilv", int'(burst_ilv), 0);
    chk("R1 flags", int'({dll_pend, rsvd_hit, field_bad, rd_dv}), 0);
    chk("R1 rise_slot", int'(rise_slot), 1);
    @(negedge clk2x);

    // R3 normal load: latency 2, burst 4, sequential
    issue(1, 0, mk(0, 2, 0, 2));
    chk("R3 lat 2", int'(lat_half), 4);
    chk("R3 bl 4", int'(burst_len), 4);
    issue(0, 1, '0);
    dv_window("R7 R8 lat2 bl4", 4, 4);

    // R3 latency 2.5, burst 8, interleaved
    issue(1, 0, mk(0, 6, 1, 3));
    chk("R3 lat 2.5", int'(lat_half), 5);
    chk("R3 bl 8", int'(burst_len), 8);
    chk("R3 interleaved", int'(burst_ilv), 1);
    issue(0, 1, '0);
    dv_window("R7 R8 lat2.5 bl8", 5, 8);

    // R9 load and read in the same slot: read keeps 2.5, burst uses new 4
    issue(1, 1, mk(0, 2, 0, 2));
    chk("R9 new lat stored", int'(lat_half), 4);
    dv_window("R9 same-slot read", 5, 4);

    // R4 DLL-reset load
    issue(1, 0, mk(2, 2, 0, 1));
    chk("R4 dll_pend set", int'(dll_pend), 1);
    chk("R4 bl stored", int'(burst_len), 2);
    // R5 reserved upper bits
    issue(1, 0, mk(3, 6, 1, 3));
    chk("R5 rsvd_hit", int'(rsvd_hit), 1);
    chk("R5 bl kept", int'(burst_len), 2);
    chk("R5 dll kept", int'(dll_pend), 1);
    @(negedge clk2x);
    chk("R5 pulse ends", int'(rsvd_hit), 0);
    // R6 reserved latency and burst codes
    issue(1, 0, mk(0, 3, 0, 2));
    chk("R6 field_bad lat", int'(field_bad), 1);
    chk("R6 lat kept", int'(lat_half), 4);
    chk("R6 dll kept", int'(dll_pend), 1);
    issue(1, 0, mk(0, 6, 0, 0));
    chk("R6 field_bad bl", int'(field_bad), 1);
    chk("R6 lat kept again", int'(lat_half), 4);
    issue(1, 0, mk(0, 2, 0, 1));
    chk("R4 dll cleared", int'(dll_pend), 0);

    // R2 commands in the off slot are ignored
    while (m_ph != 1) @(negedge clk2x);
    cyc(1, 1, mk(0, 6, 1, 3));
    chk("R2 off-slot load ignored", int'(lat_half), 4);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk2x); chk("R2 off-slot read ignored", int'(rd_dv), 0);
    end

    // R10 frequency window
    freq_mhz = 8'd120; #1;
    chk("R10 lat2 at 120", int'(cfg_warn), 1);
    issue(1, 0, mk(0, 6, 0, 1));
    chk("R10 lat2.5 at 120", int'(cfg_warn), 0);
    freq_mhz = 8'd140; #1;
    chk("R10 lat2.5 at 140", int'(cfg_warn), 1);
    freq_mhz = 8'd60; #1;
    chk("R10 below floor", int'(cfg_warn), 1);
    freq_mhz = 8'd90;
    @(negedge clk2x);

    // Random traffic, loads colliding with reads in flight (R8, R9)
    for (int n = 0; n < 4000; n++) begin
      int sel, hi, cl;
      bit m, r;
      sel = int'($urandom_range(0, 9));
      hi  = (sel < 6) ? 0 : (sel < 8) ? 2 : int'($urandom_range(0, 127));
      cl  = ($urandom_range(0, 9) < 8) ? (($urandom_range(0, 1) != 0) ? 6 : 2)
                                        : int'($urandom_range(0, 7));
      m = ($urandom_range(0, 5) == 0);
      r = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 49) == 0) freq_mhz = 8'($urandom_range(50, 150));
      cyc(m, r, mk(hi, cl, int'($urandom_range(0, 1)), int'($urandom_range(0, 7))));
    end
    repeat (12) @(negedge clk2x);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule